// File: doc/BRIEF.md
# Eight-bit end-around rotator

This block is purely combinational. It rotates an eight-bit word left by 0 to 7 places, and a three-bit select sets the amount. Bits that leave the top of the word come back in at the bottom, so the output always holds the same bits as the input, in a new order.

The word is built from four identical four-bit window slices. Each slice sees a seven-bit window of the input and rotates it by 0 to 3 places under the two low select bits. The slices form two pairs. One pair is wired for an offset of zero places and the other for an offset of four places. The top select bit drives the active-low output enables of both pairs in opposite senses. Exactly one pair therefore drives the shared tri-state output bus at any time, and the top bit adds four places to the rotation without a further multiplexer stage.

Top module: `rot8_endaround`

## Requirements
- R1: For every input word `din` and every select value `sel` from 0 to 7, `dout` equals `din` rotated left by `sel` places, so that `dout[j] = din[(j - sel) mod 8]`.
- R2: When `sel` is 0, `dout` equals `din` unchanged.
- R3: Rotation is end-around. With `din` = 8'h80 and `sel` = 1, `dout` is 8'h01, because the top bit re-enters at bit 0.
- R4: No bit is lost or added. The number of ones in `dout` always equals the number of ones in `din`.
- R5: Exactly one slice pair drives the output bus for any select, so no bit of `dout` is ever unknown or high-impedance.
- R6: When `sel[2]` is 1 and `sel[1:0]` is 0 (select 4), `dout` equals the two nibbles of `din` exchanged: `{din[3:0], din[7:4]}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Word to rotate |
| sel | input | 3 | Rotation amount; bit 2 selects the four-place offset pair |
| dout | output | 8 | Rotated word, driven by the enabled slice pair over a shared bus |

## Verification
Suppose both pairs are enabled, or neither is. Then some `dout` bits would at once read unknown or high-impedance in the same evaluation in which the select changes, and the same thing happens for every data value. A window wired to the wrong neighbour bit shows up as a wrong output bit only for the selects that route through that slice, so the bench sweeps all 256 words against all 8 selects. It checks each result in the same cycle the inputs are applied, because there is no register in the path.

// File: rtl/rot8_endaround.sv
module rot8_slice #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic [2*N-2:0] win,
  input  logic [SW-1:0]  amt,
  input  logic           oe_n,
  output tri   [N-1:0]   y
);
  logic [2*N-2:0] sh;
  logic [N-1:0]   val;

  assign sh  = win << amt;
  assign val = sh[2*N-2:N-1];
  assign y   = oe_n ? {N{1'bz}} : val;
endmodule

module rot8_endaround #(
  parameter int N = 4
) (
  input  logic [2*N-1:0]        din,
  input  logic [$clog2(N):0]    sel,
  output tri   [2*N-1:0]        dout
);
  localparam int W  = 2 * N;
  localparam int SW = $clog2(N);

  genvar p, b, m;
  generate
    for (p = 0; p < 2; p++) begin : g_path
      for (b = 0; b < 2; b++) begin : g_slice
        logic [2*N-2:0] win;
        for (m = 0; m < 2*N-1; m++) begin : g_win
          assign win[m] = din[(b*N + m + 2*W - (N-1) - p*N) % W];
        end
        rot8_slice #(.N(N), .SW(SW)) u_slice (
          .win  (win),
          .amt  (sel[SW-1:0]),
          .oe_n (p == 0 ? sel[SW] : ~sel[SW]),
          .y    (dout[b*N +: N])
        );
      end
    end
  endgenerate

  logic [2*W-1:0] dbl;
  logic [W-1:0]   ref_rot;
  assign dbl     = {din, din} << sel;
  assign ref_rot = dbl[2*W-1:W];

  always_comb begin
    assert_bus_known_R5: assert (!$isunknown(dout))
      else $error("R5: output bus not driven by exactly one pair");
    assert_rotate_R1: assert (dout === ref_rot)
      else $error("R1: rotation mismatch");
    assert_ones_kept_R4: assert ($countones(dout) == $countones(din))
      else $error("R4: bit count changed");
    if (sel == '0)
      assert_identity_R2: assert (dout === din)
        else $error("R2: zero select altered word");
    if (sel == (SW+1)'(N))
      assert_swap_R6: assert (dout === {din[N-1:0], din[W-1:N]})
        else $error("R6: half swap mismatch");
  end
endmodule

// File: tb/tb_rot8_endaround.sv
module tb_rot8_endaround;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic [2:0] sel = '0;
  wire  [7:0] dout;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] d;
    logic [2:0] s;
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  rot8_endaround dut (.din(din), .sel(sel), .dout(dout));

  always #5 clk = ~clk;

  function automatic logic [7:0] rotl(input logic [7:0] d, input int k);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = d[(j - k + 8) % 8];
    return r;
  endfunction

  function automatic int ones(input logic [7:0] v);
    int c = 0;
    for (int j = 0; j < 8; j++) c += int'(v[j]);
    return c;
  endfunction

  task automatic drive(input logic [7:0] d, input logic [2:0] s);
    item_t it;
    @(posedge clk);
    {din, sel} = {d, s};
    it.d = d; it.s = s; it.exp = rotl(d, int'(s));
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        tests++;
        if ($isunknown(dout)) begin
          fails++;
          $display("FAIL R5: dout=%b expected known %h", dout, it.exp);
        end
        tests++;
        if (dout !== it.exp) begin
          fails++;
          if (it.s == 3'd0)
            $display("FAIL R2: d=%h sel=%0d got %h expected %h", it.d, it.s, dout, it.exp);
          else if (it.s == 3'd4)
            $display("FAIL R6: d=%h sel=%0d got %h expected %h", it.d, it.s, dout, it.exp);
          else if (it.d == 8'h80 && it.s == 3'd1)
            $display("FAIL R3: d=%h sel=%0d got %h expected %h", it.d, it.s, dout, it.exp);
          else
            $display("FAIL R1: d=%h sel=%0d got %h expected %h", it.d, it.s, dout, it.exp);
        end
        tests++;
        if (ones(dout) != ones(it.d)) begin
          fails++;
          $display("FAIL R4: ones got %0d expected %0d", ones(dout), ones(it.d));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: cycles %0d expected below 200000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (dout !== 8'h00) begin
      fails++;
      $display("FAIL R2: initial dout %h expected 00", dout);
    end
    rst = 1'b0;
    drive(8'h80, 3'd1);   // R3 wrap of top bit
    drive(8'h01, 3'd7);   // R3 bit 0 travels to bit 7
    drive(8'hA5, 3'd4);   // R6 nibble swap
    drive(8'h3C, 3'd0);   // R2 identity
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 256; d++)
        drive(8'(d), 3'(s));   // R1 full sweep
    drive(8'h00, 3'd0);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule